// File: doc/BRIEF.md
# Read-Once Result Holding Register

This block keeps a second copy of a 40-bit result, taken from an upstream capture bank. The copy is taken when a data-valid strobe arrives, and that strobe comes only after a line received without error. A host on a serial bus reads the copy one byte at a time. The five bytes always come out in the same order.

Reads are destructive. Once all five bytes have been read, the result counts as stale, and every later read returns FFh until a new error-free line arrives. After reset there is no result yet, so reads also return FFh.

The host bus may have the device addressed when a strobe arrives. In that case the copy is not made at once. It waits for the next bus start or stop event, so that a transfer in progress never sees the stored bytes change under it. The bus protocol engine itself is outside this block: it supplies start and stop pulses, an addressed level, and a read-request pulse for each byte consumed.

Top module: `rdonce_bank`

## Requirements
- R1: After reset, `new_flag` is 0 and `rd_byte` is FFh.
- R2: A `dv_strobe` pulse while `addressed` is low copies `cap_data` into the stored result. `new_flag` is 1 in the following cycle.
- R3: While `new_flag` is 1, `rd_byte` shows the stored result in this order of `cap_data` lanes: [15:8], [23:16], [31:24], [39:32], then [7:0]. Each `rd_req` pulse advances to the next byte.
- R4: The fifth `rd_req` pulse of a read clears `new_flag`. From the next cycle on, `rd_byte` is FFh.
- R5: While `new_flag` is 0, `rd_byte` is FFh whatever the stored or captured data is.
- R6: A `dv_strobe` pulse while `addressed` is high changes neither `new_flag` nor `rd_byte`. The copy is made on the next `bus_start` or `bus_stop` pulse, and `new_flag` is 1 in the cycle after that pulse.
- R7: If more than one strobe arrives before a deferred copy is made, the copy takes the `cap_data` value present at the start or stop event, which is the newest capture.
- R8: A `bus_start` pulse returns the byte position to the first byte, lane [15:8].
- R9: A read of fewer than five bytes leaves `new_flag` set.
- R10: A copy made while `new_flag` is already 1 replaces the stored result and restarts the byte position at the first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_data | input | 40 | Contents of the capture bank |
| dv_strobe | input | 1 | One-cycle pulse: error-free line captured |
| bus_start | input | 1 | One-cycle pulse: start condition seen on the host bus |
| bus_stop | input | 1 | One-cycle pulse: stop condition seen on the host bus |
| addressed | input | 1 | Level: the host bus currently has this device addressed |
| rd_req | input | 1 | One-cycle pulse: the host consumed the current byte |
| rd_byte | output | 8 | Byte currently offered to the host |
| new_flag | output | 1 | Stored result is unread and valid |

## Verification
A pending flag that is stuck or lost shows up one cycle after a start or stop pulse. In that cycle `new_flag` either fails to rise, or it rises with older data. A wrong byte index shows at once on the next byte the host reads. This is why every position of the read order is compared against its own lane. A validity flag that fails to clear shows as stored data instead of FFh in the cycle after the fifth read. A copy leaking through while the device is addressed shows as `new_flag` rising before any bus event.

// File: rtl/rdonce_bank.sv
module rdonce_bank #(
  parameter int BYTES = 5,
  parameter int BW    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [BYTES*BW-1:0] cap_data,
  input  logic                dv_strobe,
  input  logic                bus_start,
  input  logic                bus_stop,
  input  logic                addressed,
  input  logic                rd_req,
  output logic [BW-1:0]       rd_byte,
  output logic                new_flag
);
  localparam int DW = BYTES * BW;
  localparam int IW = $clog2(BYTES);
  localparam logic [IW-1:0] LAST = IW'(BYTES - 1);

  logic [DW-1:0] bank;
  logic [IW-1:0] idx, lane;
  logic          pend;
  logic          bus_evt, do_copy, rd_done;

  assign bus_evt = bus_start | bus_stop;
  assign do_copy = (dv_strobe & ~addressed) | ((pend | dv_strobe) & bus_evt);
  assign rd_done = rd_req & (idx == LAST);

  assign lane    = (idx == LAST) ? '0 : idx + 1'b1;
  assign rd_byte = new_flag ? bank[lane*BW +: BW] : {BW{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank     <= '0;
      idx      <= '0;
      pend     <= 1'b0;
      new_flag <= 1'b0;
    end else begin
      if (do_copy) bank <= cap_data;

      pend <= ~do_copy & (pend | (dv_strobe & addressed));

      if (do_copy)      new_flag <= 1'b1;
      else if (rd_done) new_flag <= 1'b0;

      if (bus_start || do_copy || rd_done) idx <= '0;
      else if (rd_req)                     idx <= idx + 1'b1;
    end
  end

  AST_DIRECT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    dv_strobe && !addressed |=> new_flag); // R2
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= LAST); // R3
  AST_CLEAR_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && idx == LAST && !dv_strobe && !(pend && bus_evt) |=> !new_flag); // R4
  AST_HOLD_WHILE_ADDRESSED: assert property (@(posedge clk) disable iff (!rst_n)
    dv_strobe && addressed && !bus_evt |=> pend); // R6
  AST_FLUSH_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    pend && bus_evt |=> new_flag && !pend); // R6
  AST_START_REWINDS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> idx == '0); // R8
endmodule

// File: tb/rdonce_bank_bench.sv
module rdonce_bank_bench;
  logic        clk = 0, rst_n = 0;
  logic [39:0] cap_data = '0;
  logic        dv_strobe = 0, bus_start = 0, bus_stop = 0, addressed = 0, rd_req = 0;
  logic [7:0]  rd_byte;
  logic        new_flag;
  int total = 0, bad = 0;
  bit done = 0;

  rdonce_bank u_rdonce_bank (.clk, .rst_n, .cap_data, .dv_strobe, .bus_start,
    .bus_stop, .addressed, .rd_req, .rd_byte, .new_flag);

  always #4 clk = ~clk;

  function automatic logic [7:0] exp_byte(logic [39:0] d, int k);
    return (k < 4) ? d[8*(k+1) +: 8] : d[7:0];
  endfunction

  task automatic tick();
    @(posedge clk); #1;
    dv_strobe = 0; bus_start = 0; bus_stop = 0; rd_req = 0;
  endtask

  task automatic chk(string req, logic [39:0] act, logic [39:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_all(string req, logic [39:0] d);
    for (int k = 0; k < 5; k++) begin
      chk(req, 40'(rd_byte), 40'(exp_byte(d, k)));
      rd_req = 1; tick();
      if (k == 3) chk("R9", 40'(new_flag), 40'd1);
    end
  endtask

  task automatic t_reset();
    chk("R1", 40'(new_flag), 40'd0);
    chk("R1", 40'(rd_byte), 40'hFF);
  endtask

  task automatic t_direct_and_read();
    logic [39:0] d = 40'h5A_4433_2211;
    cap_data = d; dv_strobe = 1; tick();
    chk("R2", 40'(new_flag), 40'd1);
    addressed = 1; bus_start = 1; tick();
    read_all("R3", d);
    chk("R4", 40'(new_flag), 40'd0);
    chk("R4", 40'(rd_byte), 40'hFF);
    bus_stop = 1; tick(); addressed = 0;
  endtask

  task automatic t_stale();
    cap_data = 40'h01_0203_0405; tick();
    for (int k = 0; k < 3; k++) begin
      chk("R5", 40'(rd_byte), 40'hFF);
      rd_req = 1; tick();
    end
    chk("R5", 40'(new_flag), 40'd0);
  endtask

  task automatic t_deferred();
    logic [39:0] d = 40'hC3_B2A1_9087;
    addressed = 1; bus_start = 1; tick();
    cap_data = d; dv_strobe = 1; tick();
    for (int k = 0; k < 3; k++) begin
      chk("R6", 40'(new_flag), 40'd0);
      chk("R6", 40'(rd_byte), 40'hFF);
      tick();
    end
    bus_stop = 1; tick();
    chk("R6", 40'(new_flag), 40'd1);
    chk("R6", 40'(rd_byte), 40'(exp_byte(d, 0)));
    bus_start = 1; tick();
    read_all("R6", d);
  endtask

  task automatic t_newer();
    logic [39:0] d = 40'hEE_DDCC_BBAA;
    addressed = 1;
    cap_data = 40'h11_1111_1111; dv_strobe = 1; tick();
    cap_data = d; dv_strobe = 1; tick();
    chk("R7", 40'(new_flag), 40'd0);
    bus_start = 1; tick();
    read_all("R7", d);
  endtask

  task automatic t_restart();
    logic [39:0] d = 40'h99_8877_6655;
    addressed = 0; cap_data = d; dv_strobe = 1; tick();
    addressed = 1; bus_start = 1; tick();
    rd_req = 1; tick();
    rd_req = 1; tick();
    chk("R8", 40'(rd_byte), 40'(exp_byte(d, 2)));
    bus_start = 1; tick();
    chk("R8", 40'(rd_byte), 40'(exp_byte(d, 0)));
    rd_req = 1; tick();
    addressed = 0;
  endtask

  task automatic t_replace();
    logic [39:0] d = 40'h3C_4B5A_6978;
    cap_data = d; dv_strobe = 1; tick();
    chk("R10", 40'(new_flag), 40'd1);
    chk("R10", 40'(rd_byte), 40'(exp_byte(d, 0)));
    addressed = 1; bus_start = 1; tick();
    read_all("R10", d);
    addressed = 0;
  endtask

  initial begin
    tick(); tick(); rst_n = 1; tick();
    t_reset();
    t_direct_and_read();
    t_stale();
    t_deferred();
    t_newer();
    t_restart();
    t_replace();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule